// File: doc/BRIEF.md
# Modulo Reservation Table Slot Finder

This block keeps the resource occupancy of a software-pipelined loop body. The loop issues a new iteration every II cycles, so the occupancy table has one row for each residue of time modulo II and one column for each resource class. Each class has a fixed number of identical units, and an entry counts how many of those units are taken in that row. II is a runtime input, from 1 up to the parameter `MAX_II`.

A scheduler asks the block for a slot by giving a resource class, an earliest start time E and an optional record of where the operation was last placed. The block tests the times E, E+1, ..., E+II-1 in order, one per cycle, and returns the first time whose row still has a free unit of that class. If none of the II rows has room, the block returns a fallback time and raises a forced flag. An outside controller can then evict the conflicting entries. A separate command port reserves or releases one unit at a given (time, class). A command that would overflow or underflow an entry is refused and reported with an error pulse.

Top module: `mrt_slot_finder`

## Requirements
- R1: After reset the search is idle (`busy_o`, `done_o` and `cmd_err_o` low) and every entry is empty, so the first search of any class returns E with `forced_o` low.
- R2: A search returns the smallest time t in [E, E+II-1] whose row has a free unit of the requested class, with `forced_o` low. This holds for any runtime II from 1 to MAX_II.
- R3: A reservation at time t fills row t mod II, so it blocks every time congruent to t modulo II, and it blocks nothing else.
- R4: Class c has UNITS[c] units per row. UNITS packs one 4-bit field per class, with class 0 in the lowest bits, and the default is 2, 1, 1. A reservation on a full entry leaves the entry unchanged and raises `cmd_err_o`. Classes do not share occupancy.
- R5: When no time in the window is free and either `prev_valid_i` is low or E > `prev_time_i`, the result is E and `forced_o` is high.
- R6: When no time in the window is free, `prev_valid_i` is high and E <= `prev_time_i`, the result is min(`prev_time_i`+1, E+II-1) and `forced_o` is high.
- R7: A release frees one unit of the entry. A release on an empty entry leaves the table unchanged and raises `cmd_err_o`. The error appears as a one-cycle pulse in the cycle after the command is sampled.
- R8: `done_o` is a one-cycle pulse that arrives k+2 cycles after the start cycle, where k is the offset of the chosen time (II-1 for a forced result). The worst case is therefore II+1 cycles. `busy_o` is high between the start and the done. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ii_i | input | II_W | Initiation interval, 1..MAX_II, held stable during a search |
| srch_start_i | input | 1 | Start a search (taken only when idle) |
| srch_cls_i | input | CLS_W | Resource class to search |
| srch_early_i | input | 16 | Earliest start time E |
| prev_valid_i | input | 1 | Operation has a previous placement |
| prev_time_i | input | 16 | Previous placement time |
| srch_busy_o | output | 1 | Search in progress |
| srch_done_o | output | 1 | One-cycle result strobe |
| srch_time_o | output | 16 | Chosen time, held until the next result |
| srch_forced_o | output | 1 | Fallback rule produced the time |
| cmd_valid_i | input | 1 | Table command strobe |
| cmd_release_i | input | 1 | 1 = release a unit, 0 = reserve a unit |
| cmd_cls_i | input | CLS_W | Command resource class |
| cmd_time_i | input | 16 | Command time (row = time mod II) |
| cmd_err_o | output | 1 | Command refused (full on reserve, empty on release, bad class) |

## Verification
If a count in the table is wrong, the error shows up at the ports only through a later search or command. A search then returns a different time or a different forced flag. A command pulses `cmd_err_o` when it should not, or stays quiet when it should pulse. Both are visible within the II+1 cycles of that search, or one cycle after the command. The tests therefore fill entries to their unit count, try one more reservation or release, and then search again to show that the entry did not move. If the modulo row mapping is wrong, the search returns a time whose offset from E is wrong. If the scan counter is wrong, the latency to `srch_done_o` is wrong, so every search also checks its exact cycle count.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int unsigned TIME_W = 16;
  typedef logic [TIME_W-1:0] mrt_time_t;
  typedef enum logic [0:0] {SRCH_IDLE, SRCH_SCAN} srch_state_e;
endpackage

// File: rtl/mrt_modulo.sv
// Combinational remainder of a time value by a runtime divisor
// (restoring division, one compare-subtract per dividend bit).
module mrt_modulo
  import mrt_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input  mrt_time_t        num_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] rem_o
);
  logic [DIV_W:0] acc;

  always_comb begin
    acc = '0;
    for (int i = TIME_W - 1; i >= 0; i--) begin
      acc = {acc[DIV_W-1:0], num_i[i]};
      if (acc >= {1'b0, div_i}) begin
        acc = acc - {1'b0, div_i};
      end
    end
  end

  assign rem_o = (div_i == '0) ? '0 : acc[DIV_W-1:0];
endmodule

// File: rtl/mrt_table.sv
// Occupancy counts, one per (row, class), with a read port for the scan
// and one reserve/release write port.
module mrt_table #(
  parameter int unsigned             MAX_II  = 8,
  parameter int unsigned             NUM_CLS = 3,
  parameter int unsigned             UNIT_W  = 4,
  parameter logic [NUM_CLS*UNIT_W-1:0] UNITS = {4'd1, 4'd1, 4'd2},
  parameter int unsigned             ROW_W   = 3,
  parameter int unsigned             CLS_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_release_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [CLS_W-1:0] wr_cls_i,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [CLS_W-1:0] rd_cls_i,
  output logic             rd_free_o,
  output logic             wr_err_o
);
  logic [UNIT_W-1:0] cnt_q [MAX_II][NUM_CLS];

  logic              wr_ok_idx;
  logic              rd_ok_idx;
  logic [UNIT_W-1:0] wr_cur;
  logic [UNIT_W-1:0] wr_lim;
  logic [UNIT_W-1:0] rd_cur;
  logic [UNIT_W-1:0] rd_lim;
  logic              upd_en;
  logic [UNIT_W-1:0] upd_val;
  logic              err_d;
  logic              err_q;

  assign wr_ok_idx = (32'(wr_cls_i) < NUM_CLS) && (32'(wr_row_i) < MAX_II);
  assign rd_ok_idx = (32'(rd_cls_i) < NUM_CLS) && (32'(rd_row_i) < MAX_II);

  always_comb begin
    wr_cur = '0;
    wr_lim = '0;
    rd_cur = '0;
    rd_lim = '0;
    if (wr_ok_idx) begin
      wr_cur = cnt_q[wr_row_i][wr_cls_i];
      wr_lim = UNITS[32'(wr_cls_i)*UNIT_W +: UNIT_W];
    end
    if (rd_ok_idx) begin
      rd_cur = cnt_q[rd_row_i][rd_cls_i];
      rd_lim = UNITS[32'(rd_cls_i)*UNIT_W +: UNIT_W];
    end
  end

  assign rd_free_o = rd_ok_idx && (rd_cur < rd_lim);

  // next-state for the addressed entry and the error pulse
  always_comb begin
    upd_en  = 1'b0;
    upd_val = wr_cur;
    err_d   = 1'b0;
    if (wr_en_i) begin
      if (!wr_ok_idx) begin
        err_d = 1'b1;
      end else if (wr_release_i) begin
        if (wr_cur == '0) begin
          err_d = 1'b1;
        end else begin
          upd_en  = 1'b1;
          upd_val = wr_cur - 1'b1;
        end
      end else begin
        if (wr_cur >= wr_lim) begin
          err_d = 1'b1;
        end else begin
          upd_en  = 1'b1;
          upd_val = wr_cur + 1'b1;
        end
      end
    end
  end

  for (genvar r = 0; r < MAX_II; r++) begin : g_row
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      localparam logic [ROW_W-1:0] ROW_ID = ROW_W'(r);
      localparam logic [CLS_W-1:0] CLS_ID = CLS_W'(c);
      logic hit;
      assign hit = upd_en && (wr_row_i == ROW_ID) && (wr_cls_i == CLS_ID);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q[r][c] <= '0;
        end else if (hit) begin
          cnt_q[r][c] <= upd_val;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign wr_err_o = err_q;
endmodule

// File: rtl/mrt_search.sv
// Window scan: one candidate time per cycle from E to E+II-1,
// then the fallback rule if no row had room.
module mrt_search
  import mrt_pkg::*;
#(
  parameter int unsigned II_W  = 4,
  parameter int unsigned ROW_W = 3,
  parameter int unsigned CLS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [II_W-1:0]  ii_i,
  input  logic             start_i,
  input  logic [CLS_W-1:0] cls_i,
  input  mrt_time_t        early_i,
  input  logic             prev_valid_i,
  input  mrt_time_t        prev_time_i,
  input  logic [ROW_W-1:0] row0_i,
  input  logic             free_i,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [CLS_W-1:0] rd_cls_o,
  output logic             busy_o,
  output logic             done_o,
  output mrt_time_t        time_o,
  output logic             forced_o
);
  srch_state_e      state_q, state_d;
  mrt_time_t        early_q;
  logic [CLS_W-1:0] cls_q;
  logic             pv_q;
  mrt_time_t        pt_q;
  logic [II_W-1:0]  off_q, off_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             done_q, done_d;
  mrt_time_t        time_q, time_d;
  logic             forced_q, forced_d;
  logic             res_en;
  logic             cap_en;

  logic [II_W-1:0]  ii_last;
  logic             at_last;
  logic             row_wrap;
  mrt_time_t        cand;
  mrt_time_t        win_max;
  mrt_time_t        prev_next;
  mrt_time_t        fallback;

  assign ii_last   = ii_i - II_W'(1);
  assign at_last   = (off_q == ii_last);
  assign row_wrap  = (II_W'(row_q) == ii_last);
  assign cand      = early_q + TIME_W'(off_q);
  assign win_max   = early_q + TIME_W'(ii_last);
  assign prev_next = pt_q + TIME_W'(1);

  always_comb begin
    if (!pv_q || (early_q > pt_q)) begin
      fallback = early_q;
    end else if (prev_next < win_max) begin
      fallback = prev_next;
    end else begin
      fallback = win_max;
    end
  end

  assign cap_en = (state_q == SRCH_IDLE) && start_i;

  always_comb begin
    state_d  = state_q;
    off_d    = off_q;
    row_d    = row_q;
    done_d   = 1'b0;
    time_d   = time_q;
    forced_d = forced_q;
    res_en   = 1'b0;
    unique case (state_q)
      SRCH_IDLE: begin
        if (start_i) begin
          state_d = SRCH_SCAN;
          off_d   = '0;
          row_d   = row0_i;
        end
      end
      SRCH_SCAN: begin
        if (free_i) begin
          res_en   = 1'b1;
          time_d   = cand;
          forced_d = 1'b0;
          done_d   = 1'b1;
          state_d  = SRCH_IDLE;
        end else if (at_last) begin
          res_en   = 1'b1;
          time_d   = fallback;
          forced_d = 1'b1;
          done_d   = 1'b1;
          state_d  = SRCH_IDLE;
        end else begin
          off_d = off_q + II_W'(1);
          row_d = row_wrap ? '0 : row_q + ROW_W'(1);
        end
      end
      default: state_d = SRCH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRCH_IDLE;
      off_q   <= '0;
      row_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      row_q   <= row_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_q <= '0;
      cls_q   <= '0;
      pv_q    <= 1'b0;
      pt_q    <= '0;
    end else if (cap_en) begin
      early_q <= early_i;
      cls_q   <= cls_i;
      pv_q    <= prev_valid_i;
      pt_q    <= prev_time_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q   <= '0;
      forced_q <= 1'b0;
    end else if (res_en) begin
      time_q   <= time_d;
      forced_q <= forced_d;
    end
  end

  assign rd_row_o = row_q;
  assign rd_cls_o = cls_q;
  assign busy_o   = (state_q == SRCH_SCAN);
  assign done_o   = done_q;
  assign time_o   = time_q;
  assign forced_o = forced_q;
endmodule

// File: rtl/mrt_slot_finder.sv
module mrt_slot_finder
  import mrt_pkg::*;
#(
  parameter int unsigned               MAX_II  = 8,
  parameter int unsigned               NUM_CLS = 3,
  parameter int unsigned               UNIT_W  = 4,
  parameter logic [NUM_CLS*UNIT_W-1:0] UNITS   = {4'd1, 4'd1, 4'd2},
  localparam int unsigned              II_W    = $clog2(MAX_II + 1),
  localparam int unsigned              ROW_W   = (MAX_II > 1) ? $clog2(MAX_II) : 1,
  localparam int unsigned              CLS_W   = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [II_W-1:0]  ii_i,
  input  logic             srch_start_i,
  input  logic [CLS_W-1:0] srch_cls_i,
  input  logic [15:0]      srch_early_i,
  input  logic             prev_valid_i,
  input  logic [15:0]      prev_time_i,
  output logic             srch_busy_o,
  output logic             srch_done_o,
  output logic [15:0]      srch_time_o,
  output logic             srch_forced_o,
  input  logic             cmd_valid_i,
  input  logic             cmd_release_i,
  input  logic [CLS_W-1:0] cmd_cls_i,
  input  logic [15:0]      cmd_time_i,
  output logic             cmd_err_o
);
  logic [II_W-1:0]  srch_rem;
  logic [II_W-1:0]  cmd_rem;
  logic [ROW_W-1:0] rd_row;
  logic [CLS_W-1:0] rd_cls;
  logic             rd_free;

  mrt_modulo #(.DIV_W(II_W)) u_srch_mod (
    .num_i (srch_early_i),
    .div_i (ii_i),
    .rem_o (srch_rem)
  );

  mrt_modulo #(.DIV_W(II_W)) u_cmd_mod (
    .num_i (cmd_time_i),
    .div_i (ii_i),
    .rem_o (cmd_rem)
  );

  mrt_table #(
    .MAX_II (MAX_II),
    .NUM_CLS(NUM_CLS),
    .UNIT_W (UNIT_W),
    .UNITS  (UNITS),
    .ROW_W  (ROW_W),
    .CLS_W  (CLS_W)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (cmd_valid_i),
    .wr_release_i (cmd_release_i),
    .wr_row_i     (ROW_W'(cmd_rem)),
    .wr_cls_i     (cmd_cls_i),
    .rd_row_i     (rd_row),
    .rd_cls_i     (rd_cls),
    .rd_free_o    (rd_free),
    .wr_err_o     (cmd_err_o)
  );

  mrt_search #(
    .II_W (II_W),
    .ROW_W(ROW_W),
    .CLS_W(CLS_W)
  ) u_search (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ii_i         (ii_i),
    .start_i      (srch_start_i),
    .cls_i        (srch_cls_i),
    .early_i      (srch_early_i),
    .prev_valid_i (prev_valid_i),
    .prev_time_i  (prev_time_i),
    .row0_i       (ROW_W'(srch_rem)),
    .free_i       (rd_free),
    .rd_row_o     (rd_row),
    .rd_cls_o     (rd_cls),
    .busy_o       (srch_busy_o),
    .done_o       (srch_done_o),
    .time_o       (srch_time_o),
    .forced_o     (srch_forced_o)
  );
endmodule

// File: rtl/mrt_slot_finder_chk.sv
module mrt_slot_finder_chk #(
  parameter int unsigned II_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [II_W-1:0] ii_i,
  input logic            srch_start_i,
  input logic [15:0]     srch_early_i,
  input logic            prev_valid_i,
  input logic [15:0]     prev_time_i,
  input logic            srch_busy_o,
  input logic            srch_done_o,
  input logic [15:0]     srch_time_o,
  input logic            srch_forced_o,
  input logic            cmd_valid_i,
  input logic            cmd_err_o
);
  logic [15:0]     e_cap;
  logic [15:0]     pt_cap;
  logic            pv_cap;
  logic [II_W-1:0] ii_cap;
  logic [II_W:0]   lat_cnt;
  logic [15:0]     emax;
  logic [15:0]     f_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_cap  <= '0;
      pt_cap <= '0;
      pv_cap <= 1'b0;
      ii_cap <= '0;
    end else if (srch_start_i && !srch_busy_o) begin
      e_cap  <= srch_early_i;
      pt_cap <= prev_time_i;
      pv_cap <= prev_valid_i;
      ii_cap <= ii_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_cnt <= '0;
    end else if (srch_start_i && !srch_busy_o) begin
      lat_cnt <= (II_W + 1)'(1);
    end else if (srch_busy_o) begin
      lat_cnt <= lat_cnt + (II_W + 1)'(1);
    end
  end

  assign emax  = e_cap + 16'(ii_cap) - 16'd1;
  assign f_exp = ((pt_cap + 16'd1) < emax) ? (pt_cap + 16'd1) : emax;

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_done_o |=> !srch_done_o);

  a_r8_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srch_done_o) |-> $past(srch_busy_o));

  a_r8_bounded_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_busy_o |-> (lat_cnt <= {1'b0, ii_cap}));

  a_r2_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_done_o && !srch_forced_o) |->
      (srch_time_o >= e_cap) && ((srch_time_o - e_cap) < 16'(ii_cap)));

  a_r5_forced_at_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_done_o && srch_forced_o && (!pv_cap || (e_cap > pt_cap))) |->
      (srch_time_o == e_cap));

  a_r6_forced_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_done_o && srch_forced_o && pv_cap && (e_cap <= pt_cap)) |->
      (srch_time_o == f_exp));

  a_r7_err_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> $past(cmd_valid_i));
endmodule

bind mrt_slot_finder mrt_slot_finder_chk #(.II_W(II_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ii_i          (ii_i),
  .srch_start_i  (srch_start_i),
  .srch_early_i  (srch_early_i),
  .prev_valid_i  (prev_valid_i),
  .prev_time_i   (prev_time_i),
  .srch_busy_o   (srch_busy_o),
  .srch_done_o   (srch_done_o),
  .srch_time_o   (srch_time_o),
  .srch_forced_o (srch_forced_o),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_err_o     (cmd_err_o)
);

// File: tb/mrt_slot_finder_tb_top.sv
`timescale 1ns/1ps
module mrt_slot_finder_tb_top;
  localparam int unsigned MAX_II = 8;
  localparam int unsigned II_W   = 4;
  localparam int unsigned CLS_W  = 2;

  logic             clk;
  logic             rst_n;
  logic [II_W-1:0]  ii;
  logic             srch_start;
  logic [CLS_W-1:0] srch_cls;
  logic [15:0]      srch_early;
  logic             prev_valid;
  logic [15:0]      prev_time;
  logic             srch_busy;
  logic             srch_done;
  logic [15:0]      srch_time;
  logic             srch_forced;
  logic             cmd_valid;
  logic             cmd_release;
  logic [CLS_W-1:0] cmd_cls;
  logic [15:0]      cmd_time;
  logic             cmd_err;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit ended  = 0;

  mrt_slot_finder #(.MAX_II(MAX_II)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ii_i          (ii),
    .srch_start_i  (srch_start),
    .srch_cls_i    (srch_cls),
    .srch_early_i  (srch_early),
    .prev_valid_i  (prev_valid),
    .prev_time_i   (prev_time),
    .srch_busy_o   (srch_busy),
    .srch_done_o   (srch_done),
    .srch_time_o   (srch_time),
    .srch_forced_o (srch_forced),
    .cmd_valid_i   (cmd_valid),
    .cmd_release_i (cmd_release),
    .cmd_cls_i     (cmd_cls),
    .cmd_time_i    (cmd_time),
    .cmd_err_o     (cmd_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !ended) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmd(input bit rel, input int cls, input int t, output bit err);
    @(negedge clk);
    cmd_valid   = 1'b1;
    cmd_release = rel;
    cmd_cls     = CLS_W'(cls);
    cmd_time    = 16'(t);
    @(negedge clk);
    cmd_valid = 1'b0;
    err = cmd_err;
  endtask

  task automatic cmd_chk(input bit rel, input int cls, input int t, input bit exp_err,
                         input string req);
    bit e;
    cmd(rel, cls, t, e);
    chk(e == exp_err, req, e, exp_err);
  endtask

  task automatic search(input int cls, input int e, input bit pv, input int pt,
                        output int t, output bit f, output int lat);
    @(negedge clk);
    srch_start = 1'b1;
    srch_cls   = CLS_W'(cls);
    srch_early = 16'(e);
    prev_valid = pv;
    prev_time  = 16'(pt);
    @(negedge clk);
    srch_start = 1'b0;
    lat = 1;
    while (!srch_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    t = srch_time;
    f = srch_forced;
  endtask

  task automatic srch_chk(input int cls, input int e, input bit pv, input int pt,
                          input int exp_t, input bit exp_f, input int exp_lat,
                          input string req);
    int t; bit f; int lat;
    search(cls, e, pv, pt, t, f, lat);
    chk(t == exp_t, req, t, exp_t);
    chk(f == exp_f, req, f, exp_f);
    chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
  endtask

  // R1: reset state and empty table
  task automatic t_reset();
    chk(!srch_busy, "R1 busy", srch_busy, 0);
    chk(!srch_done, "R1 done", srch_done, 0);
    chk(!cmd_err, "R1 err", cmd_err, 0);
    ii = 4'd2;
    srch_chk(0, 5, 0, 0, 5, 0, 2, "R1 empty table");
    srch_chk(2, 3, 0, 0, 3, 0, 2, "R1 empty table cls2");
  endtask

  // R2/R3: first free time, modulo row mapping
  task automatic t_modulo_rows();
    ii = 4'd3;
    cmd_chk(0, 1, 7, 0, "R3 reserve");
    srch_chk(1, 4, 0, 0, 5, 0, 3, "R3 row 7 mod 3 blocks time 4");
    srch_chk(1, 10, 0, 0, 11, 0, 3, "R3 blocks time 10");
    srch_chk(1, 8, 0, 0, 8, 0, 2, "R3 other row free");
    srch_chk(0, 4, 0, 0, 4, 0, 2, "R2 other class free");
    cmd_chk(1, 1, 1, 0, "R7 release via congruent time");
    srch_chk(1, 4, 0, 0, 4, 0, 2, "R7 freed row");
  endtask

  // R4/R7: unit counts, refused commands leave entry unchanged
  task automatic t_units();
    ii = 4'd2;
    cmd_chk(0, 0, 0, 0, "R4 first unit");
    cmd_chk(0, 0, 2, 0, "R4 second unit");
    srch_chk(0, 4, 0, 0, 5, 0, 3, "R4 full row skipped");
    cmd_chk(0, 0, 6, 1, "R4 reserve on full");
    srch_chk(2, 0, 0, 0, 0, 0, 2, "R4 classes independent");
    cmd_chk(1, 0, 0, 0, "R7 release one");
    srch_chk(0, 0, 0, 0, 0, 0, 2, "R4 full reserve left count unchanged");
    cmd_chk(1, 0, 2, 0, "R7 release two");
    cmd_chk(1, 0, 4, 1, "R7 release on empty");
    cmd_chk(0, 0, 0, 0, "R7 empty release left count unchanged a");
    cmd_chk(0, 0, 0, 0, "R7 empty release left count unchanged b");
    cmd_chk(0, 0, 0, 1, "R4 limit after refill");
    cmd_chk(1, 0, 0, 0, "R7 cleanup");
    cmd_chk(1, 0, 0, 0, "R7 cleanup");
    cmd_chk(0, 3, 0, 1, "R4 bad class refused");
  endtask

  // R5/R6: fallback rule
  task automatic t_forced();
    ii = 4'd2;
    cmd_chk(0, 1, 0, 0, "R5 fill row0");
    cmd_chk(0, 1, 1, 0, "R5 fill row1");
    srch_chk(1, 6, 0, 0, 6, 1, 3, "R5 never scheduled");
    srch_chk(1, 6, 1, 5, 6, 1, 3, "R5 E above previous");
    srch_chk(1, 6, 1, 6, 7, 1, 3, "R6 previous plus one");
    srch_chk(1, 6, 1, 9, 7, 1, 3, "R6 capped at window end");
    ii = 4'd4;
    cmd_chk(0, 1, 2, 0, "R6 fill row2");
    cmd_chk(0, 1, 3, 0, "R6 fill row3");
    srch_chk(1, 10, 1, 10, 11, 1, 5, "R6 II4 previous plus one");
    srch_chk(1, 10, 1, 20, 13, 1, 5, "R6 II4 capped");
    for (int i = 0; i < 4; i++) cmd_chk(1, 1, i, 0, "R7 cleanup");
  endtask

  // R2/R5: II of one
  task automatic t_ii_one();
    ii = 4'd1;
    srch_chk(0, 9, 0, 0, 9, 0, 2, "R2 II1 free");
    cmd_chk(0, 0, 3, 0, "R4 II1 unit a");
    cmd_chk(0, 0, 3, 0, "R4 II1 unit b");
    srch_chk(0, 9, 0, 0, 9, 1, 2, "R5 II1 forced");
    srch_chk(0, 9, 1, 9, 9, 1, 2, "R6 II1 capped");
    cmd_chk(1, 0, 0, 0, "R7 cleanup");
    cmd_chk(1, 0, 0, 0, "R7 cleanup");
  endtask

  // R8: start while busy ignored, single done pulse
  task automatic t_busy_start();
    int lat;
    ii = 4'd8;
    for (int i = 0; i < 4; i++) cmd_chk(0, 1, i, 0, "R8 setup");
    @(negedge clk);
    srch_start = 1'b1;
    srch_cls   = 2'd1;
    srch_early = 16'd0;
    prev_valid = 1'b0;
    @(negedge clk);
    chk(srch_busy, "R8 busy after start", srch_busy, 1);
    srch_early = 16'd100;
    lat = 1;
    @(negedge clk);
    srch_start = 1'b0;
    lat++;
    while (!srch_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(srch_time == 16'd4, "R8 restart ignored", srch_time, 4);
    chk(lat == 6, "R8 latency offset4", lat, 6);
    @(negedge clk);
    chk(!srch_done, "R8 done single pulse", srch_done, 0);
    chk(!srch_busy, "R8 idle after done", srch_busy, 0);
    @(negedge clk);
    chk(!srch_done, "R8 no second result", srch_done, 0);
    for (int i = 0; i < 4; i++) cmd_chk(1, 1, i, 0, "R7 cleanup");
    srch_chk(1, 0, 0, 0, 0, 0, 2, "R8 II8 empty");
  endtask

  initial begin
    rst_n       = 1'b0;
    ii          = 4'd2;
    srch_start  = 1'b0;
    srch_cls    = '0;
    srch_early  = '0;
    prev_valid  = 1'b0;
    prev_time   = '0;
    cmd_valid   = 1'b0;
    cmd_release = 1'b0;
    cmd_cls     = '0;
    cmd_time    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modulo_rows();
    t_units();
    t_forced();
    t_ii_one();
    t_busy_start();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule